// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block holds six 32-bit event counters, an event-select register and a control register. It is reached through a simple register port. Counters 1 to 4 are programmable. Each takes an 8-bit event code that chooses between instruction-completion pulses and cycle strobes. Counter 5 always counts completed instructions and counter 6 always counts cycles. A single freeze bit stops all six counters together.

Counter 1 also acts as an alert source. When it counts across into negative territory (bit 31 becoming set), and both the counter-1 alert enable and the alert-service enable are set, the block services an alert in one step. An optional freeze-on-alert bit turns into the freeze bit. The alert-enable bit turns into an alert-hit bit, and that bit drives the interrupt request. Software acknowledges the alert by writing the hit bit back to zero.

Top module: `pmc_unit`

## Requirements
- R1: After reset, all six counters, the control register and the select register read zero, and `irq` is low.
- R2: Counter i (1 to 4) takes its event code from select-register bits [8(i-1)+7 : 8(i-1)]. Code 0x02 adds one on each cycle with `instDone` high. Code 0x1E adds one on each cycle with `cycleTick` high. Any other code never counts.
- R3: Counter 5 adds one on each cycle with `instDone` high, and counter 6 adds one on each cycle with `cycleTick` high, whatever the select register holds.
- R4: While control bit 0 (freeze) is set, no counter advances.
- R5: Counters wrap modulo 2^32, so 0xFFFFFFFF followed by one event gives 0.
- R6: An alert is raised only when counter 1 counts from 0x7FFFFFFF to 0x80000000 (not through a write), with control bit 5 (counter-1 alert enable) and bit 4 (service enable) both set. A counter that already has bit 31 set, or a written value of 0x80000000, raises nothing.
- R7: On a serviced alert, if control bit 1 (freeze-on-alert) is set, it is cleared and bit 0 is set in the same edge, so counter 1 stays at 0x80000000.
- R8: On a serviced alert, if control bit 2 (alert enable) is set, it is cleared and bit 3 (alert hit) is set. `irq` equals bit 3.
- R9: With bit 4 or bit 5 clear, a counter-1 crossing leaves the control register unchanged and `irq` low.
- R10: `irq` stays high until software writes control bit 3 to zero.
- R11: A control write in the same cycle as an alert takes priority: the register holds the written value and no alert update is applied.
- R12: Address 0 to 5 selects counters 1 to 6, address 6 the control register (bits 31:6 read zero), address 7 the select register. `rdData` is combinational on `regAddr`. A write lands at the next edge and overrides a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instDone | input | 1 | One pulse per completed instruction |
| cycleTick | input | 1 | Processor-cycle strobe |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` |
| irq | output | 1 | Alert interrupt request |

## Verification
The assertions check these properties on every cycle:
- No counter moves while frozen.
- The fixed instruction counter tracks its input.
- A crossing with every enable set always results in the hit bit and a cleared alert enable.
- The control register holds still while service is disabled.
- The interrupt request holds until a control write.

Only the bench's scenarios can show the following:
- The select codes route events correctly.
- Counters wrap.
- No alert fires on a written 0x80000000 or on an already-negative counter.
- A write wins over an alert in the same cycle.
- The register map is laid out as specified.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CNT_W    = 32;
  localparam int NUM_CTR  = 6;
  localparam int NUM_PROG = 4;
  localparam int SEL_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int CTL_W    = 6;

  localparam logic [SEL_W-1:0] EV_INST = 8'h02;
  localparam logic [SEL_W-1:0] EV_CYC  = 8'h1E;

  // control bit positions
  localparam int CB_FRZ  = 0;
  localparam int CB_FOA  = 1;
  localparam int CB_AEN  = 2;
  localparam int CB_AHIT = 3;
  localparam int CB_SVC  = 4;
  localparam int CB_NEG  = 5;

  localparam int CTL_ADDR = NUM_CTR;
  localparam int SEL_ADDR = NUM_CTR + 1;

  typedef struct packed {
    logic [NUM_CTR-1:0] incMask;
    logic [NUM_CTR-1:0] wrMask;
  } ctrStrobe_t;
endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int SelW   = SEL_W,
  parameter int NumPrg = NUM_PROG,
  parameter int AddrW  = ADDR_W,
  parameter int DataW  = CNT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instDone,
  input  logic                   cycleTick,
  input  logic                   regWe,
  input  logic [AddrW-1:0]       regAddr,
  input  logic [DataW-1:0]       regWdata,
  input  logic                   ctr1AtEdge,
  output ctrStrobe_t             strobe,
  output logic [CTL_W-1:0]       ctlQ,
  output logic [NumPrg*SelW-1:0] selQ
);
  localparam int SelTotW = NumPrg * SelW;

  logic frozen;
  logic ctlWr;
  logic selWr;
  logic alertFire;
  logic [CTL_W-1:0] ctlNext;

  assign frozen = ctlQ[CB_FRZ];
  assign ctlWr  = regWe && (regAddr == AddrW'(CTL_ADDR));
  assign selWr  = regWe && (regAddr == AddrW'(SEL_ADDR));

  for (genvar i = 0; i < NumPrg; i++) begin : g_prog
    logic [SelW-1:0] code;
    assign code = selQ[i*SelW +: SelW];
    assign strobe.incMask[i] = !frozen &&
      (((code == SelW'(EV_INST)) && instDone) || ((code == SelW'(EV_CYC)) && cycleTick));
  end
  assign strobe.incMask[NumPrg]   = !frozen && instDone;
  assign strobe.incMask[NumPrg+1] = !frozen && cycleTick;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_wr
    assign strobe.wrMask[i] = regWe && (regAddr == AddrW'(i));
  end

  assign alertFire = strobe.incMask[0] && !strobe.wrMask[0] && ctr1AtEdge &&
                     ctlQ[CB_NEG] && ctlQ[CB_SVC];

  always_comb begin
    ctlNext = ctlQ;
    if (ctlWr) begin
      ctlNext = regWdata[CTL_W-1:0];
    end else if (alertFire) begin
      if (ctlQ[CB_FOA]) begin
        ctlNext[CB_FOA] = 1'b0;
        ctlNext[CB_FRZ] = 1'b1;
      end
      if (ctlQ[CB_AEN]) begin
        ctlNext[CB_AEN]  = 1'b0;
        ctlNext[CB_AHIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      selQ <= '0;
    end else begin
      ctlQ <= ctlNext;
      if (selWr) selQ <= regWdata[SelTotW-1:0];
    end
  end
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int CntW = CNT_W,
  parameter int NumC = NUM_CTR
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrStrobe_t                strobe,
  input  logic [CntW-1:0]           regWdata,
  output logic [NumC-1:0][CntW-1:0] ctrQ,
  output logic                      ctr1AtEdge
);
  localparam logic [CntW-1:0] EdgeVal = {1'b0, {(CntW-1){1'b1}}};

  for (genvar i = 0; i < NumC; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrQ[i] <= '0;
      end else if (strobe.wrMask[i]) begin
        ctrQ[i] <= regWdata;
      end else if (strobe.incMask[i]) begin
        ctrQ[i] <= ctrQ[i] + CntW'(1);
      end
    end
  end

  assign ctr1AtEdge = (ctrQ[0] == EdgeVal);
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
  import pmc_pkg::*;
#(
  parameter int CntW  = CNT_W,
  parameter int AddrW = ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instDone,
  input  logic             cycleTick,
  input  logic             regWe,
  input  logic [AddrW-1:0] regAddr,
  input  logic [CntW-1:0]  regWdata,
  output logic [CntW-1:0]  rdData,
  output logic             irq
);
  ctrStrobe_t                       strobe;
  logic [CTL_W-1:0]                 ctlQ;
  logic [NUM_PROG*SEL_W-1:0]        selQ;
  logic [NUM_CTR-1:0][CntW-1:0]     ctrQ;
  logic                             ctr1AtEdge;

  pmc_ctrl #(.SelW(SEL_W), .NumPrg(NUM_PROG), .AddrW(AddrW), .DataW(CntW)) u_ctrl (
    .clk(clk), .rstN(rstN), .instDone(instDone), .cycleTick(cycleTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .ctr1AtEdge(ctr1AtEdge), .strobe(strobe), .ctlQ(ctlQ), .selQ(selQ)
  );

  pmc_datapath #(.CntW(CntW), .NumC(NUM_CTR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .ctrQ(ctrQ), .ctr1AtEdge(ctr1AtEdge)
  );

  always_comb begin
    rdData = '0;
    if (int'(regAddr) < NUM_CTR) rdData = ctrQ[regAddr];
    else if (regAddr == AddrW'(CTL_ADDR)) rdData = CntW'(ctlQ);
    else if (regAddr == AddrW'(SEL_ADDR)) rdData = CntW'(selQ);
  end

  assign irq = ctlQ[CB_AHIT];
endmodule

// File: rtl/pmc_unit_chk.sv
module pmc_unit_chk
  import pmc_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        instDone,
  input logic                        cycleTick,
  input logic                        regWe,
  input logic [ADDR_W-1:0]           regAddr,
  input logic [CTL_W-1:0]            ctlQ,
  input logic [NUM_PROG*SEL_W-1:0]   selQ,
  input logic [NUM_CTR-1:0][CNT_W-1:0] ctrQ,
  input logic                        irq
);
  logic c1Counts;
  assign c1Counts = !ctlQ[CB_FRZ] &&
    (((selQ[SEL_W-1:0] == EV_INST) && instDone) || ((selQ[SEL_W-1:0] == EV_CYC) && cycleTick));

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlQ[CB_FRZ] && !regWe |=> $stable(ctrQ));

  // R3
  fixed_inst_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlQ[CB_FRZ] && !(regWe && regAddr == ADDR_W'(4)) |=>
      ctrQ[4] == $past(ctrQ[4]) + CNT_W'($past(instDone)));

  // R8
  alert_svc_chk: assert property (@(posedge clk) disable iff (!rstN)
    c1Counts && !regWe && ctrQ[0] == 32'h7FFF_FFFF && ctlQ[CB_NEG] && ctlQ[CB_SVC] && ctlQ[CB_AEN]
      |=> irq && !ctlQ[CB_AEN]);

  // R9
  no_svc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlQ[CB_SVC] && !regWe |=> $stable(ctlQ));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regWe && regAddr == ADDR_W'(CTL_ADDR)) |=> irq);
endmodule

bind pmc_unit pmc_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .instDone(instDone), .cycleTick(cycleTick),
  .regWe(regWe), .regAddr(regAddr), .ctlQ(ctlQ), .selQ(selQ),
  .ctrQ(ctrQ), .irq(irq)
);

// File: tb/pmc_unit_bench.sv
module pmc_unit_bench;
  localparam time CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instDone = 1'b0;
  logic        cycleTick = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pmc_unit u_pmc_unit (
    .clk(clk), .rstN(rstN), .instDone(instDone), .cycleTick(cycleTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .rdData(rdData), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] mCtr [6];
  logic [5:0]  mCtl;
  logic [31:0] mSel;

  always @(posedge clk) begin : model
    logic inc [6];
    logic [7:0] code;
    logic alert;
    if (!rstN) begin
      for (int i = 0; i < 6; i++) mCtr[i] = 0;
      mCtl = 0;
      mSel = 0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        if (i < 4) begin
          code = mSel[8*i +: 8];
          inc[i] = (code == 8'h02 && instDone) || (code == 8'h1E && cycleTick);
        end else if (i == 4) inc[i] = instDone;
        else inc[i] = cycleTick;
        if (mCtl[0]) inc[i] = 0;
      end
      alert = inc[0] && mCtr[0] == 32'h7FFF_FFFF && mCtl[5] && mCtl[4] &&
              !(regWe && regAddr == 0);
      for (int i = 0; i < 6; i++) begin
        if (regWe && regAddr == 3'(i)) mCtr[i] = regWdata;
        else if (inc[i]) mCtr[i] = mCtr[i] + 1;
      end
      if (regWe && regAddr == 6) mCtl = regWdata[5:0];
      else if (alert) begin
        if (mCtl[1]) begin mCtl[1] = 0; mCtl[0] = 1; end
        if (mCtl[2]) begin mCtl[2] = 0; mCtl[3] = 1; end
      end
      if (regWe && regAddr == 7) mSel = regWdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    if (a < 6) return mCtr[a];
    if (a == 6) return {26'd0, mCtl};
    return mSel;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R8 irq vs model", {31'd0, irq}, {31'd0, mCtl[3]});
      chk("R12 rdData vs model", rdData, modelRead(regAddr));
    end
  end

  task automatic cyc(input logic id, input logic ct);
    @(posedge clk); #(CLK_P/4);
    regWe = 0; instDone = id; cycleTick = ct;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #(CLK_P/4);
    regWe = 1; regAddr = a; regWdata = d; instDone = 0; cycleTick = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #(CLK_P/4);
    regWe = 0; instDone = 0; cycleTick = 0; regAddr = a;
    #1 chk(tag, rdData, exp);
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int nI, nC;
    repeat (3) @(posedge clk);
    #(CLK_P/4) rstN = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R1 reset value");
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R2 / R3 event routing
    wr(7, 32'h02_05_1E_02);
    nI = 0; nC = 0;
    for (int k = 0; k < 30; k++) begin
      cyc(k % 3 != 0, k % 4 != 2);
      if (k % 3 != 0) nI++;
      if (k % 4 != 2) nC++;
    end
    rd(0, 32'(nI), "R2 ctr1 code 0x02");
    rd(1, 32'(nC), "R2 ctr2 code 0x1E");
    rd(2, 32'd0,   "R2 ctr3 other code");
    rd(3, 32'(nI), "R2 ctr4 code 0x02");
    rd(4, 32'(nI), "R3 ctr5 instructions");
    rd(5, 32'(nC), "R3 ctr6 cycles");

    // R4 freeze
    wr(6, 32'h1);
    for (int k = 0; k < 10; k++) cyc(1, 1);
    rd(4, 32'(nI), "R4 ctr5 frozen");
    rd(1, 32'(nC), "R4 ctr2 frozen");
    wr(6, 32'h0);

    // R5 wrap
    wr(4, 32'hFFFF_FFFF);
    cyc(1, 0);
    rd(4, 32'd0, "R5 wrap to zero");

    // R6 R7 R8 serviced alert
    wr(7, 32'h0000_001E);
    wr(0, 32'h7FFF_FFFD);
    wr(6, 32'h36);
    for (int k = 0; k < 6; k++) cyc(0, 1);
    rd(0, 32'h8000_0000, "R7 ctr1 frozen at threshold");
    rd(6, 32'h39, "R8 control after alert");
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    // R10 hold then acknowledge
    rd(2, 32'd0, "R10 other read");
    chk("R10 irq held", {31'd0, irq}, 32'd1);
    wr(6, 32'h30);
    rd(6, 32'h30, "R10 ack write");
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R9 service disabled
    wr(0, 32'h7FFF_FFFE);
    wr(6, 32'h26);
    for (int k = 0; k < 4; k++) cyc(0, 1);
    rd(0, 32'h8000_0002, "R9 ctr1 crossed");
    rd(6, 32'h26, "R9 control unchanged without service");
    chk("R9 irq low", {31'd0, irq}, 32'd0);
    // R9 counter-1 enable clear
    wr(0, 32'h7FFF_FFFE);
    wr(6, 32'h16);
    for (int k = 0; k < 4; k++) cyc(0, 1);
    rd(6, 32'h16, "R9 control unchanged without ctr1 enable");

    // R6 written threshold raises nothing
    wr(6, 32'h36);
    wr(0, 32'h8000_0000);
    for (int k = 0; k < 3; k++) cyc(0, 1);
    rd(0, 32'h8000_0003, "R6 counting past threshold");
    rd(6, 32'h36, "R6 no alert on written value");

    // R11 control write wins over alert
    wr(0, 32'h7FFF_FFFF);
    @(posedge clk); #(CLK_P/4);
    regWe = 1; regAddr = 6; regWdata = 32'h34; cycleTick = 1; instDone = 0;
    rd(6, 32'h34, "R11 written control kept");
    rd(0, 32'h8000_0000, "R11 counter still advanced");
    chk("R11 irq low", {31'd0, irq}, 32'd0);

    // R12 write overrides increment; upper control bits read zero
    @(posedge clk); #(CLK_P/4);
    regWe = 1; regAddr = 5; regWdata = 32'h1234_5678; cycleTick = 1;
    rd(5, 32'h1234_5678, "R12 write beats increment");
    wr(6, 32'hFFFF_FFC0);
    rd(6, 32'd0, "R12 control upper bits zero");

    cyc(0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule